// File: doc/BRIEF.md
# Knock Chain Configuration Serial Slave

This block is the 8-bit serial slave that a host processor uses to configure a knock-signal processing chain and to read its result. It receives one command byte per chip-select frame. Each accepted byte sets one of these fields: the clock prescaler code together with a data-out disable bit, the sensor channel, the band-pass centre code, the gain code, or the integrator time-constant code. One further byte switches the slave into its advanced mode.

CS, SCLK, SDI and the integrate/hold input are brought into the system clock through synchronizers. All edge detection runs in the system clock domain. After reset the data output mirrors the data input. In advanced mode the data output instead shifts out a response to the command accepted before the current frame. One of these responses carries the 10-bit integrator result.

Top module: `knock_cfg_spi`

## Requirements
- R1: While `cs_n` is low, each falling SCLK edge shifts SDI into the receive register, most significant bit first. While `cs_n` is high, SCLK and SDI have no effect on the bit count or on any setting.
- R2: When `cs_n` rises on an accepted 8-bit frame, the byte is decoded as follows. `010pppph` stores prescaler code pppp and disable bit h. `1110000c` stores channel c (0 selects channel 1, 1 selects channel 2). `00bbbbbb` stores the band-pass code. `10gggggg` stores the gain code. `110ttttt` stores the time-constant code. `01110001` enters advanced mode.
- R3: A frame with any number of falling SCLK edges other than eight changes no setting and no response.
- R4: After reset the block is in default mode, where `sdo` equals `sdi`, and all settings are zero.
- R5: In advanced mode, the byte shifted out during a frame depends on the last command accepted before that frame, and `integ_result` is sampled when `cs_n` falls. After a prescaler command the byte is result bits 7..0. After a channel command it is result bits 9..8 followed by six zeros. After band-pass, gain and time-constant commands it is 0x01, 0xE0 and 0x71. After the advanced-entry command it is 0x8E.
- R6: Once advanced mode is entered, only reset clears it.
- R7: `sdo_oe` is low while `cs_n` is high. It is also low whenever the stored disable bit is 1, even with `cs_n` low.
- R8: A frame during which `integrate` is high at any time, including when `cs_n` rises, is discarded.
- R9: `presc_code` holds the stored code. `presc_eff` equals that code for values up to 8 and is 8 for any higher code.
- R10: A byte that matches no pattern in R2 (for example 0xF0) changes no setting. It also does not replace the last accepted command used by R5.
- R11: The advanced response is loaded when `cs_n` falls. Its MSB is on `sdo` before the first falling SCLK edge, and each later falling edge presents the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| integrate | input | 1 | 1 = integrate window open, 0 = hold |
| integ_result | input | 10 | Digital integrator output |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| adv_mode | output | 1 | Advanced mode active |
| presc_code | output | 4 | Stored prescaler code |
| presc_eff | output | 4 | Prescaler code after clamping |
| sdo_hiz | output | 1 | Stored sdo disable bit |
| chan_sel | output | 1 | 0 = channel 1, 1 = channel 2 |
| bpf_code | output | 6 | Band-pass centre code |
| gain_code | output | 6 | Gain code |
| tc_code | output | 5 | Integrator time-constant code |

## Verification
In advanced mode, every command class is sent in sequence and each returned byte is compared with the reply owed to the command before it. This tells a correct one-frame lag apart from a response taken from the current byte. Frames of seven and nine bits, frames sent during integrate, and an undefined byte each separate a discarded frame from an accepted one. The check looks at both the settings and the next response. Prescaler codes 7 and 15 separate the stored code from the clamped one. With the disable bit set and `cs_n` low, the test shows that the bit overrides chip select.

// File: rtl/knock_cfg_pkg.sv
package knock_cfg_pkg;

  localparam int BYTE_W    = 8;
  localparam int PRESC_W   = 4;
  localparam int CODE6_W   = 6;
  localparam int TC_W      = 5;
  localparam int RES_W     = 10;
  localparam logic [PRESC_W-1:0] PRESC_MAX = 4'd8;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PRESC, CMD_CHAN, CMD_BPF, CMD_GAIN, CMD_TC, CMD_ADV
  } cmd_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               hiz;
    logic               chan;
    logic [CODE6_W-1:0] bpf;
    logic [CODE6_W-1:0] gain;
    logic [TC_W-1:0]    tc;
  } cfg_t;

  // Classify a received byte; patterns are disjoint.
  function automatic cmd_e decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_e c;
    c = CMD_NONE;
    if (b == 8'h71)                 c = CMD_ADV;
    else if (b[7:5] == 3'b010)      c = CMD_PRESC;
    else if (b[7:1] == 7'b1110000)  c = CMD_CHAN;
    else if (b[7:6] == 2'b00)       c = CMD_BPF;
    else if (b[7:6] == 2'b10)       c = CMD_GAIN;
    else if (b[7:5] == 3'b110)      c = CMD_TC;
    return c;
  endfunction

  // Reply owed to the previously accepted command.
  function automatic logic [BYTE_W-1:0] resp_byte(input cmd_e c,
                                                  input logic [RES_W-1:0] r);
    logic [BYTE_W-1:0] v;
    case (c)
      CMD_PRESC: v = r[7:0];
      CMD_CHAN:  v = {r[9:8], 6'b000000};
      CMD_BPF:   v = 8'h01;
      CMD_GAIN:  v = 8'hE0;
      CMD_TC:    v = 8'h71;
      CMD_ADV:   v = 8'h8E;
      default:   v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [PRESC_W-1:0] presc_effective(input logic [PRESC_W-1:0] c);
    return (c > PRESC_MAX) ? PRESC_MAX : c;
  endfunction

endpackage

// File: rtl/kc_sync.sv
module kc_sync #(
  parameter int            W      = 4,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/kc_frame.sv
module kc_frame #(
  parameter int FRAME_BITS = 8,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_s,
  input  logic                  sclk_s,
  input  logic                  sdi_s,
  input  logic                  integ_s,
  input  logic [FRAME_BITS-1:0] load_val,
  output logic [FRAME_BITS-1:0] rx_byte,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  frame_end,
  output logic                  frame_ok,
  output logic                  tx_msb
);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic cs_d, sclk_d, blk;
  logic cs_fall, sclk_fall;
  logic [FRAME_BITS-1:0] tx_q;

  assign cs_fall   = cs_d & ~cs_s;
  assign frame_end = ~cs_d & cs_s;
  assign sclk_fall = sclk_d & ~sclk_s & ~cs_s;
  assign frame_ok  = frame_end && (bit_cnt == FULL) && !blk && !integ_s;
  assign tx_msb    = tx_q[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d    <= 1'b1;
      sclk_d  <= 1'b0;
      bit_cnt <= '0;
      rx_byte <= '0;
      tx_q    <= '0;
      blk     <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_q    <= load_val;
        blk     <= integ_s;
      end else begin
        if (!cs_s && integ_s) blk <= 1'b1;
        if (sclk_fall) begin
          rx_byte <= {rx_byte[FRAME_BITS-2:0], sdi_s};
          tx_q    <= {tx_q[FRAME_BITS-2:0], 1'b0};
          if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kc_regs.sv
module kc_regs
  import knock_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [BYTE_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic              adv,
  output cmd_e              last_cmd
);
  cmd_e cmd;
  assign cmd = decode_cmd(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      adv      <= 1'b0;
      last_cmd <= CMD_NONE;
    end else if (frame_ok && cmd != CMD_NONE) begin
      last_cmd <= cmd;
      case (cmd)
        CMD_PRESC: begin
          cfg.presc <= rx_byte[4:1];
          cfg.hiz   <= rx_byte[0];
        end
        CMD_CHAN: cfg.chan <= rx_byte[0];
        CMD_BPF:  cfg.bpf  <= rx_byte[5:0];
        CMD_GAIN: cfg.gain <= rx_byte[5:0];
        CMD_TC:   cfg.tc   <= rx_byte[4:0];
        CMD_ADV:  adv      <= 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/knock_cfg_spi.sv
module knock_cfg_spi
  import knock_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               integrate,
  input  logic [RES_W-1:0]   integ_result,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               adv_mode,
  output logic [PRESC_W-1:0] presc_code,
  output logic [PRESC_W-1:0] presc_eff,
  output logic               sdo_hiz,
  output logic               chan_sel,
  output logic [CODE6_W-1:0] bpf_code,
  output logic [CODE6_W-1:0] gain_code,
  output logic [TC_W-1:0]    tc_code
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic [3:0] sync_q;
  logic cs_s, sclk_s, sdi_s, integ_s;
  logic [BYTE_W-1:0] rx_byte, load_val;
  logic [CNT_W-1:0]  bit_cnt;
  logic frame_end, frame_ok, tx_msb;
  cfg_t cfg_q;
  cmd_e last_cmd;

  kc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi, integrate}), .q(sync_q));
  assign {cs_s, sclk_s, sdi_s, integ_s} = sync_q;

  assign load_val = resp_byte(last_cmd, integ_result);

  kc_frame #(.FRAME_BITS(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .integ_s(integ_s), .load_val(load_val), .rx_byte(rx_byte),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .frame_ok(frame_ok),
    .tx_msb(tx_msb));

  kc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .rx_byte(rx_byte),
    .cfg(cfg_q), .adv(adv_mode), .last_cmd(last_cmd));

  assign sdo        = adv_mode ? tx_msb : sdi;
  assign sdo_oe     = ~cs_s & ~cfg_q.hiz;
  assign presc_code = cfg_q.presc;
  assign presc_eff  = presc_effective(cfg_q.presc);
  assign sdo_hiz    = cfg_q.hiz;
  assign chan_sel   = cfg_q.chan;
  assign bpf_code   = cfg_q.bpf;
  assign gain_code  = cfg_q.gain;
  assign tc_code    = cfg_q.tc;
endmodule

// File: rtl/kc_checker.sv
module kc_checker
  import knock_cfg_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdi,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             adv_mode,
  input logic             integ_s,
  input logic             frame_end,
  input logic             frame_ok,
  input logic [CNT_W-1:0] bit_cnt,
  input cfg_t             cfg
);
  a_r3_bad_len_discard: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && bit_cnt != CNT_W'(FRAME_BITS) |=> $stable(cfg));

  a_r8_integ_discard: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && integ_s |=> $stable(cfg) && $stable(adv_mode));

  a_r6_adv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    adv_mode |=> adv_mode);

  a_r7_hiz_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.hiz |-> !sdo_oe);

  a_r7_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdo_oe);

  a_r4_echo: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_mode |-> sdo == sdi);

  a_r2_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(cfg));
endmodule

bind knock_cfg_spi kc_checker #(.FRAME_BITS(knock_cfg_pkg::BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
  .adv_mode(adv_mode), .integ_s(integ_s), .frame_end(frame_end),
  .frame_ok(frame_ok), .bit_cnt(bit_cnt), .cfg(cfg_q));

// File: tb/knock_cfg_spi_bench.sv
module knock_cfg_spi_bench;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, integrate;
  logic [9:0] integ_result;
  logic sdo, sdo_oe, adv_mode, sdo_hiz, chan_sel;
  logic [3:0] presc_code, presc_eff;
  logic [5:0] bpf_code, gain_code;
  logic [4:0] tc_code;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  knock_cfg_spi u_knock_cfg_spi (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .integrate(integrate), .integ_result(integ_result), .sdo(sdo),
    .sdo_oe(sdo_oe), .adv_mode(adv_mode), .presc_code(presc_code),
    .presc_eff(presc_eff), .sdo_hiz(sdo_hiz), .chan_sel(chan_sel),
    .bpf_code(bpf_code), .gain_code(gain_code), .tc_code(tc_code));

  // {command, reply expected during it} with integ_result = 0x2B5
  localparam logic [15:0] VEC [7] = '{
    16'h448E, 16'hE1B5, 16'h2780, 16'h9401, 16'hC3E0, 16'h7171, 16'h008E};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits (bits past eight are zero); collect sdo before each fall.
  task automatic frame(input logic [7:0] b, input int nbits, input bit echo_chk,
                       output logic [7:0] resp);
    resp = '0;
    cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? b[7-i] : 1'b0;
      wclk(4);
      if (i < 8) resp[7-i] = sdo;
      if (echo_chk) chk("R4 echo", sdo, sdi);
      sclk = 1'b1;
      wclk(8);
      sclk = 1'b0;
      wclk(8);
    end
    cs_n = 1'b1;
    wclk(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b1; integrate = 1'b0;
    integ_result = 10'h2B5;
    wclk(5); rst_n = 1'b1; wclk(5);

    chk("R4 reset adv", adv_mode, 0);
    chk("R4 reset bpf", bpf_code, 0);
    chk("R4 reset presc", presc_code, 0);
    chk("R7 oe with cs high", sdo_oe, 0);

    frame(8'h27, 8, 1, r);
    chk("R2 bpf write", bpf_code, 6'd39);
    chk("R1 msb-first echo byte", r, 8'h27);

    frame(8'h15, 7, 1, r);
    chk("R3 seven bits", bpf_code, 6'd39);
    frame(8'h15, 9, 1, r);
    chk("R3 nine bits", bpf_code, 6'd39);

    integrate = 1'b1;
    frame(8'h94, 8, 1, r);
    integrate = 1'b0;
    wclk(5);
    chk("R8 integrate blocks", gain_code, 0);

    // R1: clocks while deselected must not count toward the next frame
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; sdi = 1'b0; wclk(8); sclk = 1'b0; wclk(8);
    end
    frame(8'h94, 8, 1, r);
    chk("R1 cs high ignored", gain_code, 6'd20);

    frame(8'h5E, 8, 1, r);
    chk("R9 stored code", presc_code, 4'd15);
    chk("R9 clamped code", presc_eff, 4'd8);
    frame(8'h4E, 8, 1, r);
    chk("R9 code 7", presc_eff, 4'd7);

    frame(8'h71, 8, 1, r);
    chk("R6 adv entered", adv_mode, 1);

    for (int i = 0; i < 7; i++) begin
      frame(VEC[i][15:8], 8, 0, r);
      chk($sformatf("R5 R11 reply step %0d", i), r, VEC[i][7:0]);
    end
    chk("R2 presc", presc_code, 4'd2);
    chk("R2 chan", chan_sel, 1);
    chk("R2 tc", tc_code, 5'd3);
    chk("R6 adv kept", adv_mode, 1);

    frame(8'hF0, 8, 0, r);
    chk("R10 reply during unknown", r, 8'h01);
    frame(8'h00, 8, 0, r);
    chk("R10 unknown not recorded", r, 8'h01);

    integrate = 1'b1;
    frame(8'hE0, 8, 0, r);
    integrate = 1'b0;
    wclk(5);
    chk("R8 chan kept", chan_sel, 1);
    frame(8'h00, 8, 0, r);
    chk("R8 reply unchanged", r, 8'h01);

    frame(8'h0A, 7, 0, r);
    frame(8'hC3, 8, 0, r);
    chk("R3 short frame no reply change", r, 8'h01);

    frame(8'h41, 8, 0, r);
    chk("R7 hiz stored", sdo_hiz, 1);
    cs_n = 1'b0; wclk(10);
    chk("R7 hiz beats cs", sdo_oe, 0);
    cs_n = 1'b1; wclk(10);

    rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(3);
    chk("R6 reset clears adv", adv_mode, 0);
    chk("R4 reset hiz", sdo_hiz, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule